// File: doc/BRIEF.md
# DRAM Event Counter Bank

This block is a bank of eight general-purpose event counters for the performance monitor of a DRAM controller. Each counter has a configuration register that holds an enable bit and a bitmap over the controller's event strobes. The strobes arrive as a vector of single-cycle pulses. While a measurement run is active, an enabled counter advances by one in every cycle in which at least one of its selected strobes is high.

Software reaches the bank through a 64-bit register port with a valid/ready handshake. A mode register selects software-controlled runs. A write to the start register clears every counter and opens a run. A write to the end register closes the run and sets a completion flag. The counter values can then be read back at fixed offsets. Some events have one strobe per rank, carried on four adjacent bitmap bits. Setting all four bits counts that event on every rank.

Top module: `dram_evt_ctr_bank`

## Requirements
- R1: After reset every counter value, the mode register, the run-active flag and the completion flag read back as zero.
- R2: Counter n's configuration register is at 0x8040 + 8·n and its value register is at 0x8080 + 8·n. A configuration register keeps bit 63 (enable) and bits 54:0 (bitmap). Its other bits read as zero.
- R3: During a run, an enabled counter adds one on each clock edge at which any of its bitmap-selected strobes is high. Strobe bit k−1 is event number k, for k from 1 to 55.
- R4: Several selected strobes high in the same cycle add exactly one.
- R5: A counter whose enable bit is clear, or any counter while no run is active, keeps its value.
- R6: A counter that holds the all-ones value of its width (49 bits by default) stays there and does not wrap.
- R7: With the mode register at 1, writing 1 to bit 0 of 0x8028 clears all counters, clears the completion flag and starts a run. Bit 1 of 0x8028 reads 1 while a run is active.
- R8: With the mode register at 1, writing 1 to bit 0 of 0x8030 ends the run. Counters then keep their values, and bit 0 of 0x8038 reads 1.
- R9: While the mode register (bits 7:0 at 0x8020) holds any value other than 1, start and end writes have no effect.
- R10: Reads of undefined offsets return zero and writes to them change nothing. Value registers ignore writes.
- R11: reqReady is always high. An accepted read gives rspValid high for exactly the next cycle, with the data on rspRdata. Writes give no response.
- R12: For an event that has a four-bit per-rank field (for example event 27 on bits 29:26), a strobe on any one of the selected rank bits counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Register request ready (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Register byte offset |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after the read |
| rspRdata | output | 64 | Read data |
| evtPulse | input | 55 | Event strobes; bit k−1 is event k |

## Verification
The assertions assume that reset is held for at least one clock and that each request is held for exactly one accepted cycle, so each read produces one response. The monotonic-count check on counter 0 assumes that the only way a counter moves backwards is the clear done by a start write. The bench drives requests and strobes only on falling edges and holds each request for one cycle. It issues every restart through the start register. A second instance with a 4-bit counter width shares the same stimulus, so the saturation corner can be reached in a few cycles.

// File: rtl/dram_ctr_pkg.sv
package dram_ctr_pkg;
  // Strobes from the control module to the counter datapath
  typedef struct packed {
    logic clearAll;   // clear every counter (start of a new run)
    logic runActive;  // run window open
  } ctrStrobe_t;
endpackage

// File: rtl/dram_ctr_ctrl.sv
module dram_ctr_ctrl
  import dram_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_EVT = 55,
  parameter int CNT_W   = 49,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  output logic                              reqReady,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  output logic                              rspValid,
  output logic [DATA_W-1:0]                 rspRdata,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]     cntVal,
  output ctrStrobe_t                        strobe,
  output logic [NUM_CTR-1:0]                cfgEn,
  output logic [NUM_CTR-1:0][NUM_EVT-1:0]   cfgMap,
  output logic                              endFlag
);
  localparam int MODE_W = 8;
  localparam logic [ADDR_W-1:0] MODE_ADR  = ADDR_W'(32'h8020);
  localparam logic [ADDR_W-1:0] START_ADR = ADDR_W'(32'h8028);
  localparam logic [ADDR_W-1:0] STOP_ADR  = ADDR_W'(32'h8030);
  localparam logic [ADDR_W-1:0] DONE_ADR  = ADDR_W'(32'h8038);
  localparam logic [ADDR_W-1:0] CFG_ADR   = ADDR_W'(32'h8040);
  localparam logic [ADDR_W-1:0] VAL_ADR   = ADDR_W'(32'h8080);

  logic [MODE_W-1:0] modeReg;
  logic              runReg;
  logic              wrAcc, rdAcc, manualMode, startHit, stopHit;
  logic [DATA_W-1:0] rdMux;

  assign reqReady   = 1'b1;
  assign wrAcc      = reqValid && reqWrite;
  assign rdAcc      = reqValid && !reqWrite;
  assign manualMode = (modeReg == MODE_W'(1));
  assign startHit   = wrAcc && manualMode && (reqAddr == START_ADR) && reqWdata[0];
  assign stopHit    = wrAcc && manualMode && (reqAddr == STOP_ADR) && reqWdata[0];

  assign strobe.clearAll  = startHit;
  assign strobe.runActive = runReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      runReg  <= 1'b0;
      endFlag <= 1'b0;
    end else begin
      if (wrAcc && reqAddr == MODE_ADR) modeReg <= reqWdata[MODE_W-1:0];
      if (startHit) begin
        runReg  <= 1'b1;
        endFlag <= 1'b0;
      end else if (stopHit) begin
        runReg  <= 1'b0;
        endFlag <= 1'b1;
      end
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgEn[n]  <= 1'b0;
        cfgMap[n] <= '0;
      end else if (wrAcc && reqAddr == CFG_ADR + ADDR_W'(8 * n)) begin
        cfgEn[n]  <= reqWdata[DATA_W-1];
        cfgMap[n] <= reqWdata[NUM_EVT-1:0];
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (reqAddr == MODE_ADR)  rdMux[MODE_W-1:0] = modeReg;
    if (reqAddr == START_ADR) rdMux[1] = runReg;
    if (reqAddr == DONE_ADR)  rdMux[0] = endFlag;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reqAddr == CFG_ADR + ADDR_W'(8 * n)) begin
        rdMux[DATA_W-1]    = cfgEn[n];
        rdMux[NUM_EVT-1:0] = cfgMap[n];
      end
      if (reqAddr == VAL_ADR + ADDR_W'(8 * n)) rdMux[CNT_W-1:0] = cntVal[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= rdAcc;
      if (rdAcc) rspRdata <= rdMux;
    end
  end
endmodule

// File: rtl/dram_ctr_datapath.sv
module dram_ctr_datapath
  import dram_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_EVT = 55,
  parameter int CNT_W   = 49
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrStrobe_t                      strobe,
  input  logic [NUM_CTR-1:0]              cfgEn,
  input  logic [NUM_CTR-1:0][NUM_EVT-1:0] cfgMap,
  input  logic [NUM_EVT-1:0]              evtPulse,
  output logic [NUM_CTR-1:0][CNT_W-1:0]   cntVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic anyHit;
    assign anyHit = |(cfgMap[n] & evtPulse);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        cntVal[n] <= '0;
      end else if (strobe.runActive && cfgEn[n] && anyHit && cntVal[n] != CNT_MAX) begin
        cntVal[n] <= cntVal[n] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dram_evt_ctr_bank.sv
module dram_evt_ctr_bank
  import dram_ctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_EVT = 55,
  parameter int CNT_W   = 49,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  input  logic [NUM_EVT-1:0] evtPulse
);
  ctrStrobe_t                      strobe;
  logic [NUM_CTR-1:0]              cfgEn;
  logic [NUM_CTR-1:0][NUM_EVT-1:0] cfgMap;
  logic [NUM_CTR-1:0][CNT_W-1:0]   cntVal;
  logic                            endFlag;

  dram_ctr_ctrl #(
    .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .cntVal(cntVal),
    .strobe(strobe), .cfgEn(cfgEn), .cfgMap(cfgMap), .endFlag(endFlag)
  );

  dram_ctr_datapath #(
    .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgEn(cfgEn),
    .cfgMap(cfgMap), .evtPulse(evtPulse), .cntVal(cntVal)
  );
endmodule

// File: rtl/dram_ctr_chk.sv
module dram_ctr_chk #(
  parameter int CNT_W = 49
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic             rspValid,
  input logic             runActive,
  input logic             clearAll,
  input logic             endFlag,
  input logic [CNT_W-1:0] cnt0
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // R11: an accepted read is answered on the next cycle
  assert_rsp_follows_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  // R11: no response without a read
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  // R7: a run always opens with cleared counters
  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runActive) |-> (cnt0 == '0));

  // R5: outside a run the counter does not move
  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!runActive && !$past(runActive)) |-> $stable(cnt0));

  // R3 / R4: within a run a counter steps by at most one per cycle
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runActive && $past(runActive) && !$past(clearAll)) |->
      (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1)));

  // R6: all-ones holds
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cnt0) == ALL_ONES && !$past(clearAll)) |-> (cnt0 == ALL_ONES));

  // R8: completion flag rises only as the run closes
  assert_done_when_stopped_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> !runActive);
endmodule

bind dram_evt_ctr_bank dram_ctr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .rspValid(rspValid), .runActive(strobe.runActive),
  .clearAll(strobe.clearAll), .endFlag(endFlag), .cnt0(cntVal[0])
);

// File: tb/dram_evt_ctr_bank_tb.sv
module dram_evt_ctr_bank_tb_top;
  localparam int NUM_EVT = 55;
  localparam int SAT_W   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic        reqReady, rspValid, satReady, satRspValid;
  logic [63:0] rspRdata, satRdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_evt_ctr_bank dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .evtPulse(evtPulse)
  );

  // Narrow-counter copy sharing the same stimulus, for the saturation case
  dram_evt_ctr_bank #(.CNT_W(SAT_W)) dut_sat_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(satReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(satRspValid), .rspRdata(satRdata), .evtPulse(evtPulse)
  );

  function automatic logic [15:0] cfgAdr(input int n);
    return 16'h8040 + 16'(8 * n);
  endfunction
  function automatic logic [15:0] valAdr(input int n);
    return 16'h8080 + 16'(8 * n);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] adr, input logic [63:0] dat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = adr; reqWdata = dat;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] adr, output logic [63:0] dat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = adr;
    @(negedge clk);
    reqValid = 1'b0;
    dat = rspRdata;
    if (!rspValid) begin
      checks++; fails++;
      $display("FAIL R11 rspValid actual=0 expected=1");
    end
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] vec, input int cycles);
    @(negedge clk);
    evtPulse = vec;
    repeat (cycles) @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic expectReg(input string tag, input logic [15:0] adr, input logic [63:0] exp);
    logic [63:0] got;
    regRead(adr, got);
    check(tag, got, exp);
  endtask

  task automatic testReset();
    expectReg("R1 mode", 16'h8020, 64'h0);
    expectReg("R1 active", 16'h8028, 64'h0);
    expectReg("R1 done", 16'h8038, 64'h0);
    for (int n = 0; n < 8; n++) expectReg("R1 counter", valAdr(n), 64'h0);
  endtask

  task automatic testCfgMap();
    regWrite(cfgAdr(7), 64'hFFFF_FFFF_FFFF_FFFF);
    expectReg("R2 cfg mask", cfgAdr(7), {1'b1, 8'h0, {55{1'b1}}});
    regWrite(cfgAdr(7), 64'h0);
    expectReg("R2 cfg clear", cfgAdr(7), 64'h0);
  endtask

  task automatic testResponse();
    @(negedge clk);
    check("R11 ready", {63'h0, reqReady}, 64'h1);
    check("R11 idle rsp", {63'h0, rspValid}, 64'h0);
    regWrite(16'h8020, 64'h0);
    check("R11 no write rsp", {63'h0, rspValid}, 64'h0);
  endtask

  task automatic testModeGate();
    regWrite(16'h8020, 64'h2);
    regWrite(16'h8028, 64'h1);
    expectReg("R9 start ignored", 16'h8028, 64'h0);
    regWrite(16'h8020, 64'h1);
    expectReg("R9 mode readback", 16'h8020, 64'h1);
  endtask

  task automatic testCount();
    regWrite(cfgAdr(0), 64'h8000_0000_0000_0001);
    regWrite(cfgAdr(1), 64'h8000_0000_0000_0005);
    regWrite(cfgAdr(2), 64'h0000_0000_0000_0001);
    regWrite(cfgAdr(3), 64'h8000_0000_3C00_0000);
    regWrite(cfgAdr(4), 64'h8040_0000_0000_0000);
    pulse(55'h1, 3);
    expectReg("R5 before run", valAdr(0), 64'h0);
    regWrite(16'h8028, 64'h1);
    expectReg("R7 active bit", 16'h8028, 64'h2);
    pulse(55'h1, 5);
    expectReg("R3 counter0", valAdr(0), 64'd5);
    expectReg("R3 counter1", valAdr(1), 64'd5);
    expectReg("R5 disabled", valAdr(2), 64'd0);
    pulse(55'h5, 3);
    expectReg("R4 one per cycle", valAdr(1), 64'd8);
    pulse(55'h1 << 28, 4);
    expectReg("R12 rank field", valAdr(3), 64'd4);
    pulse(55'h1 << 54, 2);
    expectReg("R3 event55", valAdr(4), 64'd2);
  endtask

  task automatic testEnd();
    regWrite(16'h8020, 64'h3);
    regWrite(16'h8030, 64'h1);
    expectReg("R9 end ignored", 16'h8028, 64'h2);
    regWrite(16'h8020, 64'h1);
    regWrite(16'h8030, 64'h1);
    expectReg("R8 done", 16'h8038, 64'h1);
    expectReg("R8 inactive", 16'h8028, 64'h0);
    pulse(55'h1, 3);
    expectReg("R8 held", valAdr(0), 64'd8);
  endtask

  task automatic testUndefined();
    regWrite(16'h8000, 64'hDEAD_BEEF);
    expectReg("R10 undefined read", 16'h8000, 64'h0);
    expectReg("R10 end reg reads zero", 16'h8030, 64'h0);
    regWrite(valAdr(0), 64'h123);
    expectReg("R10 value read-only", valAdr(0), 64'd8);
  endtask

  task automatic testRestartSat();
    logic [63:0] got;
    regWrite(16'h8028, 64'h1);
    expectReg("R7 cleared", valAdr(0), 64'd0);
    expectReg("R7 done cleared", 16'h8038, 64'h0);
    pulse(55'h1, 20);
    regRead(valAdr(0), got);
    check("R3 long run", got, 64'd20);
    check("R6 saturate", satRdata, 64'd15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCfgMap();
    testResponse();
    testModeGate();
    testCount();
    testEnd();
    testUndefined();
    testRestartSat();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule